// File: doc/BRIEF.md
# Address and Data Match Trigger Unit

This block watches every memory access or instruction the core presents and decides which of a set of debug triggers match it. Each trigger is described by a control word and a target word. The control word selects the trigger flavour (classic or extended), which access kinds and privilege levels it watches, how the value is compared with the target, whether it links to the next trigger, and what should happen when it fires. The value compared is whatever the pipeline presents: a load or store address or datum, or an instruction address.

On each cycle the unit gives a per-trigger local-hit vector, a single fire flag for chains that are fully matched, and the action code of the chain that fires. Triggers that belong to a chain that fires have their sticky hit flag set on the next clock edge. Software clears those flags per trigger.

Top module: `trig_match`

## Requirements
- R1: After an active-low reset, `hit_o` is all zeros.
- R2: A trigger can hit only if the presented access kind (`kind_i` bit 0 load, bit 1 store, bit 2 execute) has its matching enable set in control bits 0 (load), 1 (store) or 2 (execute). With `kind_i` at zero, no trigger hits.
- R3: The flavour sits in control bits 31:28: 2 is classic, 6 is extended, and any other value never hits. The privilege code `priv_i` is 0 for user, 1 for supervisor, 3 for machine and 2 for a reserved level that never hits. Without virtualisation, user needs control bit 3, supervisor bit 4 and machine bit 6. Machine mode ignores `virt_i`.
- R4: With `virt_i` high, user and supervisor need control bits 23 and 24 respectively on an extended trigger. A classic trigger never hits at virtualised user or supervisor level.
- R5: A classic trigger hits only when control bit 18 equals `after_i`. An extended trigger hits only when `after_i` is 0.
- R6: Compare code (control bits 10:7) 0 hits on value equal to target. Code 2 hits on value >= target, and code 3 on value < target. Both of these compare unsigned.
- R7: Code 1 compares value and target under a mask. Let k be the number of trailing one bits of the target. The mask is all ones shifted left by k+1, and it is zero when k >= 31.
- R8: Code 4 hits when the value's lower 16 bits ANDed with target[31:16] equal target[15:0]. Code 5 does the same with the value's upper 16 bits.
- R9: Codes 8, 9, 12 and 13 hit exactly when codes 0, 1, 4 and 5 would not. Codes 6, 7, 10, 11, 14 and 15 never hit.
- R10: Control bit 11 links trigger i to trigger i+1, and the bit is ignored on the last trigger. A chain fires only when every trigger in it has a local hit. `fire_o` is high when any chain fires.
- R11: `act_o` carries control bits 15:12 of the last trigger of the lowest-numbered firing chain. It is 0 when nothing fires.
- R12: A chain whose last trigger has action 0 (breakpoint exception) does not fire while `ie_i` is high. An action of 1 (enter debug) fires regardless of `ie_i`.
- R13: `hit_o[i]` is set on the clock edge after a cycle in which a chain containing trigger i fires, and stays set until `hit_clr_i[i]`. When a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_i | input | NTRIG*XLEN | Control words, trigger i at [i*XLEN +: XLEN] |
| tgt_i | input | NTRIG*XLEN | Target words, trigger i at [i*XLEN +: XLEN] |
| val_i | input | XLEN | Address or data value being checked |
| kind_i | input | 3 | Access kind: bit 0 load, bit 1 store, bit 2 execute |
| priv_i | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualised execution |
| after_i | input | 1 | Timing class of this check: 0 before, 1 after |
| ie_i | input | 1 | Interrupts enabled, suppresses breakpoint-action chains |
| hit_clr_i | input | NTRIG | Per-trigger clear of the sticky hit flags |
| lhit_o | output | NTRIG | Per-trigger local match |
| fire_o | output | 1 | Some chain is fully matched and not suppressed |
| act_o | output | 4 | Action code of the lowest firing chain |
| hit_o | output | NTRIG | Sticky hit flags |

## Verification
The hardest case to reach is a chain that fires only because several triggers match the same value at once, each under a different compare code. Random values almost never satisfy an equality or a half-word mask. The stimulus therefore builds the value from the current targets most of the time: it copies a target, or flips one bit of it. This drives linked triggers into partial and full chain matches. Directed cases also pin down the masked-compare boundary where the target is all ones or has only bit 31 clear, and they cover a set and a clear arriving in the same cycle.

// File: rtl/trig_match.sv
module trig_match #(
  parameter int NTRIG = 4,
  parameter int XLEN  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NTRIG*XLEN-1:0]  ctl_i,
  input  logic [NTRIG*XLEN-1:0]  tgt_i,
  input  logic [XLEN-1:0]        val_i,
  input  logic [2:0]             kind_i,
  input  logic [1:0]             priv_i,
  input  logic                   virt_i,
  input  logic                   after_i,
  input  logic                   ie_i,
  input  logic [NTRIG-1:0]       hit_clr_i,
  output logic [NTRIG-1:0]       lhit_o,
  output logic                   fire_o,
  output logic [3:0]             act_o,
  output logic [NTRIG-1:0]       hit_o
);
  localparam int HALF = XLEN / 2;

  logic [NTRIG-1:0] lnk, memfire;
  logic [3:0]       act_a [NTRIG];
  logic [NTRIG:0]   ok_tail;
  logic [3:0]       last_act [NTRIG+1];

  function automatic logic [XLEN-1:0] cmp_mask(input logic [XLEN-1:0] d);
    int  k;
    logic run;
    k = 0;
    run = 1'b1;
    for (int b = 0; b < XLEN; b++) begin
      run = run & d[b];
      if (run) k = b + 1;
    end
    if (k >= XLEN - 1) return '0;
    return {XLEN{1'b1}} << (k + 1);
  endfunction

  function automatic logic val_cmp(input logic [3:0] code, input logic [XLEN-1:0] v,
                                   input logic [XLEN-1:0] d);
    logic [XLEN-1:0] m;
    logic r, ok;
    m = cmp_mask(d);
    case (code[2:0])
      3'd0:    r = (v == d);
      3'd1:    r = ((v & m) == (d & m));
      3'd2:    r = (v >= d);
      3'd3:    r = (v < d);
      3'd4:    r = ((v[HALF-1:0] & d[XLEN-1:HALF]) == d[HALF-1:0]);
      3'd5:    r = ((v[XLEN-1:HALF] & d[XLEN-1:HALF]) == d[HALF-1:0]);
      default: r = 1'b0;
    endcase
    ok = code[3] ? (code[1] == 1'b0 && code[2:0] != 3'd2 && code[2:0] != 3'd3
                    && code[2:0] != 3'd6 && code[2:0] != 3'd7)
                 : (code[2:0] <= 3'd5);
    return ok & (r ^ code[3]);
  endfunction

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    logic [XLEN-1:0] c, t;
    logic old_t, new_t, kind_ok, mode_ok, time_ok;
    assign c = ctl_i[i*XLEN +: XLEN];
    assign t = tgt_i[i*XLEN +: XLEN];
    assign old_t = (c[XLEN-1 -: 4] == 4'd2);
    assign new_t = (c[XLEN-1 -: 4] == 4'd6);
    assign kind_ok = |(kind_i & c[2:0]);
    always_comb begin
      case (priv_i)
        2'd3:    mode_ok = c[6];
        2'd1:    mode_ok = virt_i ? (new_t & c[24]) : c[4];
        2'd0:    mode_ok = virt_i ? (new_t & c[23]) : c[3];
        default: mode_ok = 1'b0;
      endcase
    end
    assign time_ok = old_t ? (c[18] == after_i) : !after_i;
    assign lhit_o[i] = (old_t | new_t) & kind_ok & mode_ok & time_ok & val_cmp(c[10:7], val_i, t);
    assign act_a[i] = c[15:12];
    if (i == NTRIG - 1) begin : g_last
      assign lnk[i] = 1'b0;
    end else begin : g_mid
      assign lnk[i] = c[11];
    end
  end

  always_comb begin
    ok_tail[NTRIG]  = 1'b1;
    last_act[NTRIG] = '0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      ok_tail[i]  = lhit_o[i] & (lnk[i] ? ok_tail[i+1] : 1'b1);
      last_act[i] = lnk[i] ? last_act[i+1] : act_a[i];
    end
  end

  always_comb begin
    logic run, prev_lnk, found;
    run = 1'b0;
    prev_lnk = 1'b0;
    found = 1'b0;
    act_o = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (!prev_lnk) begin
        run = ok_tail[i] & !(last_act[i] == 4'd0 && ie_i);
        if (run && !found) begin
          act_o = last_act[i];
          found = 1'b1;
        end
      end
      memfire[i] = run;
      prev_lnk = lnk[i];
    end
  end

  assign fire_o = |memfire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_o <= '0;
    else        hit_o <= (hit_o & ~hit_clr_i) | memfire;
  end

  // R10
  fire_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (lhit_o != '0));
  // R12
  ie_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && ie_i) |-> (act_o != 4'd0));
  // R13
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit_o & $past(hit_o & ~hit_clr_i)) == $past(hit_o & ~hit_clr_i)));
  // R13
  hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_o |=> ((hit_o & ~$past(hit_o)) == '0));
  // R2
  no_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == 3'b000) |-> (lhit_o == '0));
  // R11
  idle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_o |-> (act_o == 4'd0));
endmodule

// File: tb/sim_trig_match.sv
module sim_trig_match;
  localparam int N = 4;
  localparam int X = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [X-1:0] ctl [N];
  logic [X-1:0] tgt [N];
  logic [N*X-1:0] ctl_f, tgt_f;
  logic [X-1:0] val = '0;
  logic [2:0] kind = '0;
  logic [1:0] priv = '0;
  logic virt = 1'b0, after = 1'b0, ie = 1'b0;
  logic [N-1:0] clr = '0;
  logic [N-1:0] lhit, hit;
  logic fire;
  logic [3:0] act;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string scen = "reset";
  logic [N-1:0] m_hit = '0, m_mf = '0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign ctl_f[g*X +: X] = ctl[g];
    assign tgt_f[g*X +: X] = tgt[g];
  end

  trig_match #(.NTRIG(N), .XLEN(X)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_f), .tgt_i(tgt_f), .val_i(val),
    .kind_i(kind), .priv_i(priv), .virt_i(virt), .after_i(after), .ie_i(ie),
    .hit_clr_i(clr), .lhit_o(lhit), .fire_o(fire), .act_o(act), .hit_o(hit));

  // modes = {vs, vu, m, s, u}
  function automatic logic [31:0] mk(input int typ, input logic [2:0] kinds,
      input logic [4:0] modes, input int code, input bit ch, input int a, input bit tim);
    logic [31:0] r;
    r = '0;
    r[31:28] = typ[3:0];
    r[2:0] = kinds;
    r[3] = modes[0]; r[4] = modes[1]; r[6] = modes[2];
    r[23] = modes[3]; r[24] = modes[4];
    r[10:7] = code[3:0];
    r[11] = ch;
    r[15:12] = a[3:0];
    r[18] = tim;
    return r;
  endfunction

  function automatic bit m_match(input logic [31:0] v, input logic [31:0] d, input int code);
    int base, k;
    bit neg, r;
    logic [31:0] m;
    neg = (code >= 8);
    base = neg ? code - 8 : code;
    if (code == 6 || code == 7 || code == 10 || code == 11 || code == 14 || code == 15)
      return 0;
    k = 0;
    while (k < 32 && d[k]) k++;
    m = (k >= 31) ? 32'h0 : (32'hFFFF_FFFF << (k + 1));
    case (base)
      0: r = (v == d);
      1: r = ((v & m) == (d & m));
      2: r = (v >= d);
      3: r = (v < d);
      4: r = ((v[15:0] & d[31:16]) == d[15:0]);
      default: r = ((v[31:16] & d[31:16]) == d[15:0]);
    endcase
    return r ^ neg;
  endfunction

  function automatic bit m_lhit(input int i);
    logic [31:0] c;
    bit old_t, new_t, en;
    c = ctl[i];
    old_t = (c[31:28] == 4'd2);
    new_t = (c[31:28] == 4'd6);
    if (!old_t && !new_t) return 0;
    if ((kind & c[2:0]) == 3'b0) return 0;
    if (priv == 2'd3) en = c[6];
    else if (priv == 2'd1) en = virt ? (new_t && c[24]) : c[4];
    else if (priv == 2'd0) en = virt ? (new_t && c[23]) : c[3];
    else en = 0;
    if (!en) return 0;
    if (old_t && (c[18] != after)) return 0;
    if (new_t && after) return 0;
    return m_match(val, tgt[i], int'(c[10:7]));
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] got=%h expected=%h", req, scen, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] el;
    bit efire, all_ok;
    logic [3:0] eact;
    int j, st;
    for (int i = 0; i < N; i++) el[i] = m_lhit(i);
    efire = 0; eact = 0; m_mf = '0;
    j = 0;
    while (j < N) begin
      st = j;
      while (j < N - 1 && ctl[j][11]) j++;
      all_ok = 1;
      for (int q = st; q <= j; q++) if (!el[q]) all_ok = 0;
      if (all_ok && !(ctl[j][15:12] == 4'd0 && ie)) begin
        for (int q = st; q <= j; q++) m_mf[q] = 1'b1;
        if (!efire) eact = ctl[j][15:12];
        efire = 1;
      end
      j++;
    end
    chk("R2 local hit", 32'(lhit), 32'(el));
    chk("R10 fire", 32'(fire), 32'(efire));
    chk("R11 action", 32'(act), 32'(eact));
    chk("R13 sticky hit", 32'(hit), 32'(m_hit));
  endtask

  task automatic step();
    #5;
    compare_all();
    @(posedge clk);
    #1;
    m_hit = (m_hit & ~clr) | m_mf;
  endtask

  task automatic expect1(input string req, input logic got, input logic exp);
    chk(req, 32'(got), 32'(exp));
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < N; i++) begin ctl[i] = '0; tgt[i] = '0; end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    int codes [12] = '{0, 1, 2, 3, 4, 5, 8, 9, 12, 13, 6, 11};
    int typs [6] = '{2, 6, 2, 6, 0, 15};
    clear_cfg();
    repeat (3) @(posedge clk);
    #1;
    // R1: hit flags cleared by reset
    expect1("R1 reset hit", |hit, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    scen = "R1";
    step();

    // R2 access kinds
    scen = "R2";
    ctl[0] = mk(2, 3'b001, 5'b00100, 0, 0, 1, 0); tgt[0] = 32'h1000;
    val = 32'h1000; priv = 2'd3; kind = 3'b001;
    #5 expect1("R2 load hit", lhit[0], 1'b1);
    step();
    kind = 3'b010; step();
    kind = 3'b100; step();
    ctl[0] = mk(2, 3'b110, 5'b00100, 0, 0, 1, 0);
    kind = 3'b100; step();
    kind = 3'b000; step();

    // R3 privilege and flavour
    scen = "R3";
    kind = 3'b100; priv = 2'd0; step();
    ctl[0] = mk(2, 3'b100, 5'b00001, 0, 0, 1, 0); step();
    priv = 2'd1; step();
    priv = 2'd2; step();
    ctl[0] = mk(9, 3'b100, 5'b11111, 0, 0, 1, 0); priv = 2'd3; step();
    ctl[0] = mk(6, 3'b100, 5'b00010, 0, 0, 1, 0); priv = 2'd1; step();

    // R4 virtualised levels
    scen = "R4";
    ctl[0] = mk(6, 3'b100, 5'b01000, 0, 0, 1, 0); priv = 2'd0; virt = 1'b1;
    #5 expect1("R4 vu hit", lhit[0], 1'b1);
    step();
    priv = 2'd1; step();
    ctl[0] = mk(6, 3'b100, 5'b10000, 0, 0, 1, 0); step();
    ctl[0] = mk(2, 3'b100, 5'b11011, 0, 0, 1, 0); priv = 2'd0; step();
    priv = 2'd3; ctl[0] = mk(2, 3'b100, 5'b00100, 0, 0, 1, 0); step();
    virt = 1'b0;

    // R5 timing
    scen = "R5";
    ctl[0] = mk(2, 3'b100, 5'b00100, 0, 0, 1, 1); after = 1'b0; step();
    after = 1'b1;
    #5 expect1("R5 after hit", lhit[0], 1'b1);
    step();
    ctl[0] = mk(6, 3'b100, 5'b00100, 0, 0, 1, 1); step();
    after = 1'b0; step();

    // R6 equal and unsigned ordering
    scen = "R6";
    ctl[0] = mk(2, 3'b001, 5'b00100, 2, 0, 1, 0); kind = 3'b001;
    tgt[0] = 32'h0000_0001; val = 32'h8000_0000;
    #5 expect1("R6 unsigned ge", lhit[0], 1'b1);
    step();
    val = 32'h0; step();
    ctl[0] = mk(2, 3'b001, 5'b00100, 3, 0, 1, 0); step();
    tgt[0] = 32'h10; val = 32'h10; step();
    ctl[0] = mk(2, 3'b001, 5'b00100, 0, 0, 1, 0); val = 32'h11; step();

    // R7 masked compare
    scen = "R7";
    ctl[0] = mk(2, 3'b001, 5'b00100, 1, 0, 1, 0);
    tgt[0] = 32'h0000_10FF; val = 32'h0000_1155;
    #5 expect1("R7 masked hit", lhit[0], 1'b1);
    step();
    val = 32'h0000_1355; step();
    tgt[0] = 32'hFFFF_FFFF; val = 32'h1234_5678; step();
    tgt[0] = 32'h7FFF_FFFF; val = 32'h0; step();
    tgt[0] = 32'hBFFF_FFFF; val = 32'h0; step();
    val = 32'h8000_0000; step();

    // R8 half-word compares
    scen = "R8";
    ctl[0] = mk(2, 3'b001, 5'b00100, 4, 0, 1, 0);
    tgt[0] = 32'h00FF_0034; val = 32'h0000_AB34;
    #5 expect1("R8 low half hit", lhit[0], 1'b1);
    step();
    val = 32'h0000_AB35; step();
    ctl[0] = mk(2, 3'b001, 5'b00100, 5, 0, 1, 0); val = 32'hAB34_0000; step();
    val = 32'h0000_AB34; step();

    // R9 negated and reserved codes
    scen = "R9";
    ctl[0] = mk(2, 3'b001, 5'b00100, 12, 0, 1, 0); val = 32'h0000_AB34; step();
    ctl[0] = mk(2, 3'b001, 5'b00100, 8, 0, 1, 0); tgt[0] = 32'h5; val = 32'h5;
    #5 expect1("R9 negated equal", lhit[0], 1'b0);
    step();
    val = 32'h6; step();
    ctl[0] = mk(2, 3'b001, 5'b00100, 6, 0, 1, 0); step();
    ctl[0] = mk(2, 3'b001, 5'b00100, 10, 0, 1, 0); step();

    // R10 chains
    scen = "R10";
    clear_cfg(); step();
    ctl[0] = mk(2, 3'b001, 5'b00100, 0, 1, 0, 0); tgt[0] = 32'h40;
    ctl[1] = mk(2, 3'b001, 5'b00100, 2, 0, 1, 0); tgt[1] = 32'h20;
    val = 32'h40;
    #5 expect1("R10 chain fires", fire, 1'b1);
    step();
    tgt[1] = 32'h80; step();
    ctl[3] = mk(6, 3'b001, 5'b00100, 0, 1, 1, 0); tgt[3] = 32'h40; step();

    // R11 action from last, lowest chain wins
    scen = "R11";
    tgt[1] = 32'h20; ctl[3] = mk(6, 3'b001, 5'b00100, 0, 1, 5, 0);
    ie = 1'b1;
    #5 expect1("R11 last action", act == 4'd1, 1'b1);
    step();
    tgt[1] = 32'h80; step();
    ie = 1'b0; step();

    // R12 interrupt-enable suppression
    scen = "R12";
    clear_cfg();
    ctl[2] = mk(2, 3'b001, 5'b00100, 0, 0, 0, 0); tgt[2] = 32'h40; ie = 1'b1;
    #5 expect1("R12 suppressed", fire, 1'b0);
    step();
    ie = 1'b0; step();

    // R13 sticky flags
    scen = "R13";
    ctl[2] = '0; step();
    #5 expect1("R13 held", hit[2], 1'b1);
    step();
    clr = 4'b0100; step();
    clr = 4'b0000; step();
    ctl[2] = mk(2, 3'b001, 5'b00100, 0, 0, 0, 0); step();
    clr = 4'b0100; step();
    clr = 4'b0000; ctl[2] = '0; step();
    #5 expect1("R13 set wins", hit[2], 1'b1);
    step();

    // mixed sweep
    scen = "sweep";
    for (int n = 0; n < 3000; n++) begin
      if (n % 4 == 0) begin
        for (int i = 0; i < N; i++) begin
          c = $urandom;
          c[31:28] = typs[$urandom % 6][3:0];
          c[10:7] = codes[$urandom % 12][3:0];
          c[15:12] = ($urandom % 2) ? 4'd1 : 4'd0;
          ctl[i] = c;
          case ($urandom % 3)
            0: tgt[i] = $urandom;
            1: tgt[i] = (32'h1 << ($urandom % 32)) - 1;
            default: tgt[i] = $urandom % 256;
          endcase
        end
      end
      case ($urandom % 3)
        0: val = tgt[$urandom % N];
        1: val = tgt[$urandom % N] ^ (32'h1 << ($urandom % 32));
        default: val = $urandom;
      endcase
      kind = 3'b001 << ($urandom % 3);
      priv = 2'($urandom % 4);
      virt = ($urandom % 4 == 0);
      after = ($urandom % 3 == 0);
      ie = ($urandom % 2 == 0);
      clr = ($urandom % 8 == 0) ? N'(1 << ($urandom % N)) : '0;
      step();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule